// File: doc/BRIEF.md
# Packed byte add execute unit

This block sits in the execute stage of a single-issue, in-order 32-bit core. It recognises exactly one custom R-type instruction word and executes it as four independent byte-wide additions. The 32-bit register operands are split into byte lanes. Each lane is summed on its own, and a carry out of one lane never reaches the next. The lane sums are packed back into a 32-bit result, which is written to the destination register.

To make dependent instruction sequences checkable in isolation, the unit carries its own 32-entry register file. Operands are read from it combinationally. The result is registered and written back on the next clock edge, so a following instruction always reads the fresh value. A second write port stands in for the write-back of every other instruction of the core. A combinational observation port reads any register.

Top module: `pba_unit`

## Requirements
- R1: An instruction word matches only when bits 6:0 are 0110011, bits 14:12 are 000 and bits 31:25 are 0000011. Changing any of these bits makes it non-matching.
- R2: The destination index is taken from bits 11:7, the first source index from bits 19:15 and the second source index from bits 24:20.
- R3: The result is four byte lanes. Lane k (bits 8k+7:8k) is the sum of the two operands' lane k modulo 256. A lane overflow does not change any other lane (for example, 0xFFFFFFFF plus 0x00010203 gives 0xFF000102).
- R4: Register 0 always reads as zero, both as an operand and on the observation port.
- R5: A matching instruction whose destination index is 0 shows match_o high and wr_en_o low, and no register changes.
- R6: A non-matching instruction word gives match_o low, wr_en_o low, rd_o zero and result_o zero one cycle later, and it leaves the register file unchanged.
- R7: Outputs are registered. match_o, wr_en_o, rd_o and result_o reflect the instruction presented before the preceding rising edge, and the register file is written on that same edge. A back-to-back instruction reading that register sees the new value (starting from 1, adding 2 and then adding 3 to the same register leaves 6).
- R8: While rst_n is low, all registers and all outputs are cleared to zero.
- R9: On the other-instruction write port, ext_we writes ext_data into register ext_idx on the rising edge. This write is dropped when ext_idx is 0, or when the packed add writes in the same cycle (the packed add has priority).
- R10: peek_data shows register peek_idx combinationally, including writes made on the last edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 32 | Instruction word presented this cycle |
| ext_we | input | 1 | Write enable from other instructions' write-back |
| ext_idx | input | 5 | Register index for that write |
| ext_data | input | 32 | Data for that write |
| peek_idx | input | 5 | Observation port register index |
| peek_data | output | 32 | Observation port register value |
| match_o | output | 1 | Registered: last instruction was the packed add |
| wr_en_o | output | 1 | Registered: the packed add wrote a register |
| rd_o | output | 5 | Registered destination index |
| result_o | output | 32 | Registered packed lane sum |

## Verification
The lane adder is tried with small values that never carry, to check lane placement. It is also tried with all-ones against small values, so that three lanes overflow and any carry leaking into a neighbour becomes visible. A zero operand shows that the other operand passes through unchanged, and hundreds of random operand pairs are checked per lane against a model. Decode is exercised by flipping single bits in each fixed field and by using unusual register indices, which tells field misplacement apart from a wrong constant. Chained adds to one register, writes to register 0 and conflicting same-cycle writes separate the write-back timing and priority from the arithmetic itself.

// File: rtl/pba_pkg.sv
package pba_pkg;
  localparam logic [6:0] PBA_OPCODE = 7'b0110011;
  localparam logic [2:0] PBA_FUNCT3 = 3'b000;
  localparam logic [6:0] PBA_FUNCT7 = 7'b0000011;
  localparam int         REG_IDX_W  = 5;

  typedef struct packed {
    logic                 hit;
    logic [REG_IDX_W-1:0] rd;
    logic [REG_IDX_W-1:0] rs1;
    logic [REG_IDX_W-1:0] rs2;
  } pba_dec_t;
endpackage

// File: rtl/pba_decode.sv
module pba_decode
  import pba_pkg::*;
(
  input  logic [31:0] instr,
  output pba_dec_t    dec
);
  logic opc_ok, f3_ok, f7_ok;

  always_comb begin
    opc_ok  = (instr[6:0]   == PBA_OPCODE);
    f3_ok   = (instr[14:12] == PBA_FUNCT3);
    f7_ok   = (instr[31:25] == PBA_FUNCT7);
    dec.hit = opc_ok & f3_ok & f7_ok;
    dec.rd  = instr[11:7];
    dec.rs1 = instr[19:15];
    dec.rs2 = instr[24:20];
  end
endmodule

// File: rtl/pba_lane_adder.sv
module pba_lane_adder #(
  parameter int XLEN   = 32,
  parameter int LANE_W = 8
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] sum
);
  localparam int LANES = XLEN / LANE_W;

  function automatic logic [LANE_W-1:0] lane_add(input logic [LANE_W-1:0] x,
                                                  input logic [LANE_W-1:0] y);
    logic [LANE_W:0] wide;
    wide = {1'b0, x} + {1'b0, y};
    return wide[LANE_W-1:0];
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign sum[l*LANE_W +: LANE_W] = lane_add(a[l*LANE_W +: LANE_W],
                                              b[l*LANE_W +: LANE_W]);
  end
endmodule

// File: rtl/pba_regfile.sv
module pba_regfile #(
  parameter int XLEN  = 32,
  parameter int NREGS = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(NREGS)-1:0] widx,
  input  logic [XLEN-1:0]          wdata,
  input  logic [$clog2(NREGS)-1:0] ra_idx,
  output logic [XLEN-1:0]          ra_data,
  input  logic [$clog2(NREGS)-1:0] rb_idx,
  output logic [XLEN-1:0]          rb_data,
  input  logic [$clog2(NREGS)-1:0] rc_idx,
  output logic [XLEN-1:0]          rc_data
);
  localparam int IDX_W = $clog2(NREGS);

  logic [XLEN-1:0] mem [NREGS];

  function automatic logic [XLEN-1:0] rd_port(input logic [IDX_W-1:0] i);
    return (i == '0) ? '0 : mem[i];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) mem[i] <= '0;
    end else if (we && widx != '0) begin
      mem[widx] <= wdata;
    end
  end

  assign ra_data = rd_port(ra_idx);
  assign rb_data = rd_port(rb_idx);
  assign rc_data = rd_port(rc_idx);
endmodule

// File: rtl/pba_unit.sv
module pba_unit
  import pba_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int LANE_W = 8,
  parameter int NREGS  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] instr,
  input  logic        ext_we,
  input  logic [4:0]  ext_idx,
  input  logic [31:0] ext_data,
  input  logic [4:0]  peek_idx,
  output logic [31:0] peek_data,
  output logic        match_o,
  output logic        wr_en_o,
  output logic [4:0]  rd_o,
  output logic [31:0] result_o
);
  pba_dec_t dec;
  logic            dec_hit;
  logic [4:0]      dec_rd;
  logic            add_we;
  logic [XLEN-1:0] op_a, op_b, lane_sum;
  logic            rf_we;
  logic [4:0]      rf_widx;
  logic [XLEN-1:0] rf_wdata;

  pba_decode u_dec (.instr(instr), .dec(dec));

  assign dec_hit = dec.hit;
  assign dec_rd  = dec.rd;
  assign add_we  = dec_hit && (dec_rd != '0);

  pba_regfile #(.XLEN(XLEN), .NREGS(NREGS)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(rf_we), .widx(rf_widx), .wdata(rf_wdata),
    .ra_idx(dec.rs1), .ra_data(op_a),
    .rb_idx(dec.rs2), .rb_data(op_b),
    .rc_idx(peek_idx), .rc_data(peek_data)
  );

  pba_lane_adder #(.XLEN(XLEN), .LANE_W(LANE_W)) u_add (
    .a(op_a), .b(op_b), .sum(lane_sum)
  );

  always_comb begin
    if (add_we) begin
      rf_we    = 1'b1;
      rf_widx  = dec_rd;
      rf_wdata = lane_sum;
    end else begin
      rf_we    = ext_we;
      rf_widx  = ext_idx;
      rf_wdata = ext_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      match_o  <= 1'b0;
      wr_en_o  <= 1'b0;
      rd_o     <= '0;
      result_o <= '0;
    end else begin
      match_o  <= dec_hit;
      wr_en_o  <= add_we;
      rd_o     <= dec_hit ? dec_rd : '0;
      result_o <= dec_hit ? lane_sum : '0;
    end
  end
endmodule

// File: rtl/pba_unit_chk.sv
module pba_unit_chk #(
  parameter int XLEN   = 32,
  parameter int LANE_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            dec_hit,
  input logic [4:0]      dec_rd,
  input logic [XLEN-1:0] op_a,
  input logic [XLEN-1:0] op_b,
  input logic            match_o,
  input logic            wr_en_o,
  input logic [4:0]      rd_o,
  input logic [31:0]     result_o,
  input logic [4:0]      peek_idx,
  input logic [31:0]     peek_data
);
  localparam int LANES = XLEN / LANE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
    // R3: each lane follows its own operands one cycle earlier
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      dec_hit |=> result_o[l*LANE_W +: LANE_W] ==
        LANE_W'($past(op_a[l*LANE_W +: LANE_W]) + $past(op_b[l*LANE_W +: LANE_W])));
  end

  a_r5_rd0_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (match_o && rd_o != 5'd0));

  a_r6_nomatch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_hit |=> (!match_o && !wr_en_o && rd_o == 5'd0 && result_o == 32'd0));

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    dec_hit |=> (match_o && rd_o == $past(dec_rd)));

  a_r4_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (peek_idx == 5'd0) |-> (peek_data == 32'd0));
endmodule

bind pba_unit pba_unit_chk #(.XLEN(XLEN), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_hit(dec_hit), .dec_rd(dec_rd),
  .op_a(op_a), .op_b(op_b), .match_o(match_o), .wr_en_o(wr_en_o),
  .rd_o(rd_o), .result_o(result_o), .peek_idx(peek_idx), .peek_data(peek_data)
);

// File: tb/pba_unit_test.sv
module pba_unit_test;
  localparam time PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = 32'd0;
  logic        ext_we = 1'b0;
  logic [4:0]  ext_idx = 5'd0;
  logic [31:0] ext_data = 32'd0;
  logic [4:0]  peek_idx = 5'd0;
  logic [31:0] peek_data;
  logic        match_o, wr_en_o;
  logic [4:0]  rd_o;
  logic [31:0] result_o;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] model_rf [32];

  pba_unit uut (
    .clk(clk), .rst_n(rst_n), .instr(instr),
    .ext_we(ext_we), .ext_idx(ext_idx), .ext_data(ext_data),
    .peek_idx(peek_idx), .peek_data(peek_data),
    .match_o(match_o), .wr_en_o(wr_en_o), .rd_o(rd_o), .result_o(result_o)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] enc(input int rd, input int rs1, input int rs2);
    return {7'b0000011, 5'(rs2), 5'(rs1), 3'b000, 5'(rd), 7'b0110011};
  endfunction

  // reference: integer arithmetic per byte, reduced modulo 256
  function automatic logic [31:0] ref_sum(input logic [31:0] x, input logic [31:0] y);
    logic [31:0] r = 0;
    for (int k = 0; k < 4; k++) begin
      int s;
      s = (int'((x >> (8*k)) & 32'hFF) + int'((y >> (8*k)) & 32'hFF)) % 256;
      r = r | (32'(s) << (8*k));
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_rf(input string tag);
    for (int i = 0; i < 32; i++) begin
      peek_idx = 5'(i);
      #1;
      chk(tag, peek_data, model_rf[i]);
    end
  endtask

  // one instruction cycle; model and comparison on every clock
  task automatic step(input logic [31:0] ins, input logic lwe, input int lidx,
                      input logic [31:0] ldat, input string tag);
    logic hit;
    int rd, rs1, rs2;
    logic [31:0] a, b, s;
    logic add_w;
    instr = ins; ext_we = lwe; ext_idx = 5'(lidx); ext_data = ldat;
    hit = (ins & 32'hFE00_707F) == 32'h0600_0033;
    rd  = int'((ins >> 7)  & 32'h1F);
    rs1 = int'((ins >> 15) & 32'h1F);
    rs2 = int'((ins >> 20) & 32'h1F);
    a = model_rf[rs1]; b = model_rf[rs2];
    s = ref_sum(a, b);
    add_w = hit && rd != 0;
    @(posedge clk);
    if (add_w) model_rf[rd] = s;
    else if (lwe && lidx != 0) model_rf[lidx] = ldat;
    @(negedge clk);
    chk({tag, " match"}, 32'(match_o), 32'(hit));
    chk({tag, " wr_en"}, 32'(wr_en_o), 32'(add_w));
    chk({tag, " rd"}, 32'(rd_o), hit ? 32'(rd) : 32'd0);
    chk({tag, " result"}, result_o, hit ? s : 32'd0);
    if (add_w) begin
      peek_idx = 5'(rd); #1;
      chk({tag, " writeback"}, peek_data, s);
    end
  endtask

  task automatic load(input int idx, input logic [31:0] v);
    step(32'h0000_0013, 1'b1, idx, v, "R9 load");
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    for (int i = 0; i < 32; i++) model_rf[i] = 32'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    chk("R8 match", 32'(match_o), 0);
    chk("R8 result", result_o, 0);
    rst_n = 1'b1;
    chk_rf("R8 regs");

    // R1 R3 lane placement, no carries
    load(1, 32'h0102_0304); load(2, 32'h0204_0608);
    step(enc(3, 1, 2), 0, 0, 0, "R3 no-carry");
    chk("R3 value", result_o, 32'h0306_090C);
    // R3 overflow isolation
    load(1, 32'hFFFF_FFFF); load(2, 32'h0001_0203);
    step(enc(3, 1, 2), 0, 0, 0, "R3 overflow");
    chk("R3 overflow value", result_o, 32'hFF00_0102);
    // zero operand passes through
    load(1, 32'h0102_0304); load(2, 32'h0);
    step(enc(3, 1, 2), 0, 0, 0, "R3 zero operand");
    chk("R3 passthru", result_o, 32'h0102_0304);
    // R4 register zero as both sources
    step(enc(4, 0, 0), 0, 0, 0, "R4 x0 sources");
    chk("R4 value", result_o, 32'h0);
    // R5 destination zero
    step(enc(0, 1, 1), 0, 0, 0, "R5 rd0");
    chk("R5 wr_en", 32'(wr_en_o), 0);
    peek_idx = 5'd0; #1; chk("R4 peek x0", peek_data, 0);
    // R7 back-to-back dependence
    load(1, 32'd1); load(2, 32'd2); load(3, 32'd3);
    step(enc(1, 1, 2), 0, 0, 0, "R7 chain1");
    step(enc(1, 1, 3), 0, 0, 0, "R7 chain2");
    peek_idx = 5'd1; #1; chk("R7 chain value", peek_data, 32'd6);
    // R2 unusual indices
    load(17, 32'h1122_3344); load(9, 32'h8070_6050);
    step(enc(31, 17, 9), 0, 0, 0, "R2 fields");
    chk("R2 rd", 32'(rd_o), 31);
    // R1 R6 single-bit perturbations of fixed fields
    for (int bitn = 0; bitn < 32; bitn++) begin
      if (bitn < 7 || (bitn >= 12 && bitn <= 14) || bitn >= 25) begin
        snap = model_rf[5];
        step(enc(5, 17, 9) ^ (32'd1 << bitn), 0, 0, 0, "R1/R6 nomatch");
        chk("R6 rf unchanged", model_rf[5], snap);
      end
    end
    chk_rf("R6 regs");
    // R9 priority: packed add wins over same-cycle ext write
    step(enc(6, 17, 9), 1'b1, 6, 32'hDEAD_BEEF, "R9 conflict");
    peek_idx = 5'd6; #1; chk("R9 add wins", peek_data, ref_sum(32'h1122_3344, 32'h8070_6050));
    step(32'h0, 1'b1, 0, 32'hFFFF_FFFF, "R9 x0 write");
    peek_idx = 5'd0; #1; chk("R9 x0 stays", peek_data, 0);
    // R10 observation port across all regs
    chk_rf("R10 regs");
    // R3 random pairs against lane model
    for (int n = 0; n < 300; n++) begin
      load(10, $urandom); load(11, $urandom);
      step(enc(12, 10, 11), 0, 0, 0, "R3 random");
    end
    // R8 reset mid-run clears state
    rst_n = 1'b0; @(posedge clk); @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 32; i++) model_rf[i] = 32'd0;
    chk("R8 re-reset wr_en", 32'(wr_en_o), 0);
    chk_rf("R8 re-reset regs");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule